// File: doc/BRIEF.md
# Key-Protected Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a selectable prescaler tap. It has two modes. In watchdog mode, a wrap of the count from 0xFF to 0x00 emits a fixed-length overflow pulse and can also raise a reset request. In interval mode, the same wrap raises a level interrupt instead. Software reaches the block through a small 16-bit register port with three locations. The control/status register is at byte offset 0, the count is at offset 2 and the reset control is at offset 4.

The count can be reloaded only by a 16-bit write whose upper byte carries the key value 0x5A. Any other write to the count location is dropped, so a stray store cannot hold off the watchdog. Entering software standby clears the count and the prescaler. Reads are combinational, and the upper byte of the read data is always zero.

Control/status byte layout: bit 7 is the timer enable, bit 6 selects the mode (1 for watchdog, 0 for interval), bit 5 is the overflow flag, bits 4:3 always read as 1, and bits 2:0 are the clock-select field. Reset control byte layout: bit 6 is the reset enable, bits 4:0 always read as 1, and bits 7 and 5 read as 0.

Top module: `guard_timer`

## Requirements
- R1: After power-on reset, offset 0 reads 0x0018, offset 2 reads 0x0000 and offset 4 reads 0x001F.
- R2: While enabled, the count rises by one on each prescaler tick. The clock-select codes 0 through 7 divide the system clock by 1, 4, 16, 32, 64, 256, 1024 and 4096. The prescaler restarts from zero whenever the timer is stopped.
- R3: A write to offset 2 loads the low byte into the count only when the access is 16 bits wide (busWide=1) and the upper byte is 0x5A. A byte-wide write or a wrong key leaves every piece of state unchanged.
- R4: While enable (bit 7) is 0, the count holds its value.
- R5: In watchdog mode, each wrap from 0xFF to 0x00 drives wdOverflow high for exactly PULSE_LEN (128) clocks, starting with the wrap edge. A new wrap during the pulse restarts it.
- R6: A wrap sets the flag (bit 5) in either mode. Writing 0 to bit 5 of the control byte clears the flag, and writing 1 leaves it as it is. A wrap in the same cycle as a clearing write wins.
- R7: intervalIrq is high exactly while the flag is set and interval mode (bit 6 = 0) is selected.
- R8: When reset enable (offset 4, bit 6) is set at the wrap, resetReq is high for the same clocks as that wdOverflow pulse. Otherwise resetReq stays low.
- R9: While standby is high, the count and the prescaler are held at zero.
- R10: A keyed load in the same cycle as a tick takes the loaded value, not the incremented one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low power-on reset |
| standby | input | 1 | High while software standby is in force |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 for a write, 0 for a read |
| busWide | input | 1 | 1 for a 16-bit access, 0 for a byte access |
| busAddr | input | 3 | Byte offset of the register |
| busWdata | input | 16 | Write data |
| busRdata | output | 16 | Read data for busAddr, with the upper byte zero |
| wdOverflow | output | 1 | Watchdog overflow pulse |
| intervalIrq | output | 1 | Level interval-timer interrupt |
| resetReq | output | 1 | Reset request that goes with the overflow pulse |

## Verification
The bench aims at the key gate with both a wrong key and a byte-wide write carrying the right key. A design that checks only the data or ignores the access size would reload the count and miss the deadline. It drives flag writes of 0 and of 1 while the interrupt is pending. A design that treats any write as a clear would drop a live interrupt. It measures the overflow pulse and the reset request clock by clock, which catches lengths that are off by one. It also sweeps the slowest and a fast prescaler tap, forces a load on a tick, and raises standby mid-count. A wrong tap or a lost priority shows up there as a count that drifts from the reference model.

// File: rtl/guard_timer_pkg.sv
package guard_timer_pkg;

  localparam int CNT_W   = 8;
  localparam int PRE_W   = 12;
  localparam int BUS_W   = 16;
  localparam logic [7:0] CNT_KEY = 8'h5A;

  // command strobes from control to datapath
  typedef struct packed {
    logic             clear;    // standby: zero count and prescaler
    logic             load;     // keyed count load
    logic             run;      // enabled and not in standby
    logic [2:0]       clkSel;   // prescaler tap code
    logic [CNT_W-1:0] loadVal;  // value for a keyed load
  } dpCmd_t;

  // prescaler tap as a power of two: 1,4,16,32,64,256,1024,4096
  function automatic logic [3:0] tapShift(input logic [2:0] sel);
    logic [3:0] s;
    case (sel)
      3'd0: s = 4'd0;
      3'd1: s = 4'd2;
      3'd2: s = 4'd4;
      3'd3: s = 4'd5;
      3'd4: s = 4'd6;
      3'd5: s = 4'd8;
      3'd6: s = 4'd10;
      default: s = 4'd12;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/guard_timer_dp.sv
module guard_timer_dp
  import guard_timer_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpCmd_t           cmd,
  output logic [CNT_W-1:0] count,
  output logic             tick,
  output logic             ovfEvent
);

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] tapMask;

  // low bits that must all be ones for a tick at the selected division
  always_comb begin
    tapMask = (PRE_W'(1) << tapShift(cmd.clkSel)) - PRE_W'(1);
  end

  always_comb begin
    tick     = cmd.run && ((preCnt & tapMask) == tapMask);
    ovfEvent = tick && !cmd.clear && !cmd.load && (count == {CNT_W{1'b1}});
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (cmd.run) begin
      preCnt <= preCnt + PRE_W'(1);
    end else begin
      preCnt <= '0;
    end
  end

  // priority: standby clear, then keyed load, then tick
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count <= '0;
    end else if (cmd.clear) begin
      count <= '0;
    end else if (cmd.load) begin
      count <= cmd.loadVal;
    end else if (tick) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/guard_timer_ctrl.sv
module guard_timer_ctrl
  import guard_timer_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int PULSE_LEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              ovfEvent,
  output dpCmd_t            cmd,
  output logic [BUS_W-1:0]  busRdata,
  output logic              timerEn,
  output logic              wdMode,
  output logic              ovfFlag,
  output logic              wdOverflow,
  output logic              intervalIrq,
  output logic              resetReq
);

  localparam logic [ADDR_W-1:0] OFF_CTRL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_COUNT = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] OFF_RST   = ADDR_W'(4);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic       wrStb;
  logic       ctrlWr;
  logic       rstWr;
  logic       keyOk;
  logic [2:0] clkSel;
  logic       rstEn;
  logic [PW-1:0] pulseLeft;
  logic       pulseRst;

  always_comb begin
    wrStb  = busSel && busWr;
    ctrlWr = wrStb && (busAddr == OFF_CTRL);
    rstWr  = wrStb && (busAddr == OFF_RST);
    keyOk  = wrStb && busWide && (busAddr == OFF_COUNT) &&
             (busWdata[BUS_W-1:8] == CNT_KEY);
  end

  always_comb begin
    cmd.clear   = standby;
    cmd.load    = keyOk;
    cmd.run     = timerEn && !standby;
    cmd.clkSel  = clkSel;
    cmd.loadVal = busWdata[CNT_W-1:0];
  end

  // control/status fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timerEn <= 1'b0;
      wdMode  <= 1'b0;
      clkSel  <= 3'd0;
    end else if (ctrlWr) begin
      timerEn <= busWdata[7];
      wdMode  <= busWdata[6];
      clkSel  <= busWdata[2:0];
    end
  end

  // overflow flag: a wrap beats a clearing write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfFlag <= 1'b0;
    end else if (ovfEvent) begin
      ovfFlag <= 1'b1;
    end else if (ctrlWr && !busWdata[5]) begin
      ovfFlag <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstEn <= 1'b0;
    end else if (rstWr) begin
      rstEn <= busWdata[6];
    end
  end

  // fixed-length overflow pulse, restarted by each watchdog wrap
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pulseLeft <= '0;
      pulseRst  <= 1'b0;
    end else if (ovfEvent && wdMode) begin
      pulseLeft <= PW'(PULSE_LEN);
      pulseRst  <= rstEn;
    end else if (pulseLeft != '0) begin
      pulseLeft <= pulseLeft - PW'(1);
    end
  end

  always_comb begin
    wdOverflow  = (pulseLeft != '0);
    resetReq    = wdOverflow && pulseRst;
    intervalIrq = ovfFlag && !wdMode;
  end

  // combinational read mux
  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFF_CTRL:  busRdata[7:0] = {timerEn, wdMode, ovfFlag, 2'b11, clkSel};
      OFF_COUNT: busRdata[7:0] = count;
      OFF_RST:   busRdata[7:0] = {1'b0, rstEn, 1'b0, 5'b11111};
      default:   busRdata      = '0;
    endcase
  end

endmodule

// File: rtl/guard_timer.sv
module guard_timer
  import guard_timer_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int PULSE_LEN = 128
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              standby,
  input  logic              busSel,
  input  logic              busWr,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [15:0]       busWdata,
  output logic [15:0]       busRdata,
  output logic              wdOverflow,
  output logic              intervalIrq,
  output logic              resetReq
);

  dpCmd_t           cmd;
  logic [CNT_W-1:0] count;
  logic             tick;
  logic             ovfEvent;
  logic             timerEn;
  logic             wdMode;
  logic             ovfFlag;

  guard_timer_ctrl #(.ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .standby    (standby),
    .busSel     (busSel),
    .busWr      (busWr),
    .busWide    (busWide),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .count      (count),
    .ovfEvent   (ovfEvent),
    .cmd        (cmd),
    .busRdata   (busRdata),
    .timerEn    (timerEn),
    .wdMode     (wdMode),
    .ovfFlag    (ovfFlag),
    .wdOverflow (wdOverflow),
    .intervalIrq(intervalIrq),
    .resetReq   (resetReq)
  );

  guard_timer_dp u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .count   (count),
    .tick    (tick),
    .ovfEvent(ovfEvent)
  );

endmodule

// File: rtl/guard_timer_chk.sv
module guard_timer_chk #(
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              standby,
  input logic              busSel,
  input logic              busWr,
  input logic              busWide,
  input logic [ADDR_W-1:0] busAddr,
  input logic [15:0]       busWdata,
  input logic [7:0]        count,
  input logic              tick,
  input logic              ovfEvent,
  input logic              timerEn,
  input logic              wdMode,
  input logic              ovfFlag,
  input logic              wdOverflow,
  input logic              resetReq
);

  logic cntWr;
  logic goodLoad;
  always_comb begin
    cntWr    = busSel && busWr && (busAddr == ADDR_W'(2));
    goodLoad = cntWr && busWide && (busWdata[15:8] == 8'h5A);
  end

  // R9
  standby_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    standby |=> (count == 8'h00));

  // R3
  bad_key_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cntWr && !goodLoad && !standby && !tick) |=> (count == $past(count)));

  // R4
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!timerEn && !standby && !goodLoad) |=> (count == $past(count)));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !standby && !goodLoad && count != 8'hFF) |=> (count == $past(count) + 8'd1));

  // R10
  load_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (goodLoad && !standby) |=> (count == $past(busWdata[7:0])));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |=> ovfFlag);

  // R5
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wdOverflow) |-> $past(ovfEvent && wdMode));

  // R8
  reset_with_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetReq |-> wdOverflow);

endmodule

bind guard_timer guard_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .standby   (standby),
  .busSel    (busSel),
  .busWr     (busWr),
  .busWide   (busWide),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .count     (count),
  .tick      (tick),
  .ovfEvent  (ovfEvent),
  .timerEn   (timerEn),
  .wdMode    (wdMode),
  .ovfFlag   (ovfFlag),
  .wdOverflow(wdOverflow),
  .resetReq  (resetReq)
);

// File: tb/guard_timer_tb.sv
module guard_timer_tb;

  localparam int PLEN = 128;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        standby = 1'b0;
  logic        busSel = 1'b0;
  logic        busWr = 1'b0;
  logic        busWide = 1'b0;
  logic [2:0]  busAddr = 3'd0;
  logic [15:0] busWdata = 16'h0000;
  logic [15:0] busRdata;
  logic        wdOverflow;
  logic        intervalIrq;
  logic        resetReq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  // reference state
  int mPre, mCnt, mCks, mPulse;
  bit mEn, mMode, mFlag, mRstEn, mPulseRst;

  always #5 clk = ~clk;

  guard_timer #(.PULSE_LEN(PLEN)) u_dut (
    .clk(clk), .rstN(rstN), .standby(standby),
    .busSel(busSel), .busWr(busWr), .busWide(busWide),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .wdOverflow(wdOverflow), .intervalIrq(intervalIrq), .resetReq(resetReq)
  );

  function automatic int divOf(int cks);
    int d[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
    return d[cks];
  endfunction

  function automatic int modelRead(int a);
    case (a)
      0: return (mEn << 7) | (mMode << 6) | (mFlag << 5) | 8'h18 | mCks;
      2: return mCnt;
      4: return (mRstEn << 6) | 8'h1F;
      default: return 0;
    endcase
  endfunction

  task automatic modelStep();
    bit run, tk, wr, ld, ovf;
    if (!rstN) begin
      mPre = 0; mCnt = 0; mCks = 0; mPulse = 0;
      mEn = 0; mMode = 0; mFlag = 0; mRstEn = 0; mPulseRst = 0;
      return;
    end
    run = mEn && !standby;
    tk  = run && ((mPre % divOf(mCks)) == divOf(mCks) - 1);
    wr  = busSel && busWr;
    ld  = wr && busWide && busAddr == 3'd2 && busWdata[15:8] == 8'h5A;
    ovf = tk && !standby && !ld && mCnt == 255;
    if (ovf && mMode) begin
      mPulse = PLEN; mPulseRst = mRstEn;
    end else if (mPulse > 0) mPulse--;
    if (ovf) mFlag = 1;
    else if (wr && busAddr == 3'd0 && !busWdata[5]) mFlag = 0;
    mPre = run ? (mPre + 1) % 4096 : 0;
    if (standby) mCnt = 0;
    else if (ld) mCnt = busWdata[7:0];
    else if (tk) mCnt = (mCnt + 1) % 256;
    if (wr && busAddr == 3'd0) begin
      mEn = busWdata[7]; mMode = busWdata[6]; mCks = busWdata[2:0];
    end
    if (wr && busAddr == 3'd4) mRstEn = busWdata[6];
  endtask

  task automatic check(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareAll();
    check(busAddr == 3'd2 ? "R2 count" : "R1 register read", busRdata, modelRead(busAddr));
    check("R5 wdOverflow", wdOverflow, mPulse > 0);
    check("R7 intervalIrq", intervalIrq, mFlag && !mMode);
    check("R8 resetReq", resetReq, (mPulse > 0) && mPulseRst);
  endtask

  task automatic cycle();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    if (rstN) compareAll();
  endtask

  task automatic idle(int n);
    busSel = 0; busWr = 0;
    repeat (n) cycle();
  endtask

  int echo;
  task automatic wr(logic [2:0] a, logic [15:0] d, bit wide);
    busSel = 1; busWr = 1; busWide = wide; busAddr = a; busWdata = d;
    cycle();
    echo = busRdata;
    busSel = 0; busWr = 0;
  endtask

  task automatic rdCheck(string tag, logic [2:0] a, int exp);
    busSel = 1; busWr = 0; busAddr = a;
    #1;
    check(tag, busRdata, exp);
    busSel = 0;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int hi, rq, snap;
    repeat (3) cycle();
    @(negedge clk); rstN = 1;
    idle(2);
    // R1 reset values
    rdCheck("R1 ctrl", 3'd0, 16'h0018);
    rdCheck("R1 count", 3'd2, 16'h0000);
    rdCheck("R1 rstctl", 3'd4, 16'h001F);

    // R3 keyed load and rejected writes
    wr(3'd2, 16'h5AF0, 1);
    rdCheck("R3 keyed load", 3'd2, 16'h00F0);
    wr(3'd2, 16'h1234, 1);
    rdCheck("R3 wrong key", 3'd2, 16'h00F0);
    wr(3'd2, 16'h5A11, 0);
    rdCheck("R3 byte write", 3'd2, 16'h00F0);
    idle(20);
    rdCheck("R4 hold disabled", 3'd2, 16'h00F0);

    // interval mode, divide by 1
    wr(3'd0, 16'h0080, 0);
    idle(30);
    check("R7 irq after wrap", intervalIrq, 1);
    check("R5 no pulse interval", wdOverflow, 0);
    rdCheck("R6 flag set", 3'd0, 16'h00B8);
    wr(3'd0, 16'h00A0, 0);
    check("R6 write one keeps", intervalIrq, 1);
    wr(3'd0, 16'h0000, 0);
    check("R6 R7 cleared", intervalIrq, 0);
    busAddr = 3'd2; idle(1);
    snap = busRdata;
    idle(15);
    rdCheck("R4 hold after stop", 3'd2, snap);

    // watchdog mode with reset enable
    wr(3'd4, 16'h0040, 0);
    rdCheck("R8 rstctl readback", 3'd4, 16'h005F);
    wr(3'd2, 16'h5AFE, 1);
    wr(3'd0, 16'h00C0, 0);
    hi = 0; rq = 0;
    for (int i = 0; i < 200; i++) begin
      idle(1);
      if (wdOverflow) hi++;
      if (resetReq) rq++;
      if (intervalIrq) check("R7 no irq in watchdog", intervalIrq, 0);
    end
    check("R5 pulse length", hi, PLEN);
    check("R8 reset length", rq, PLEN);
    wr(3'd0, 16'h0000, 0);
    wr(3'd4, 16'h0000, 0);

    // R2 prescaler taps
    wr(3'd2, 16'h5A00, 1);
    wr(3'd0, 16'h0081, 0);
    idle(40);
    rdCheck("R2 div4", 3'd2, 16'h000A);
    wr(3'd0, 16'h0000, 0);
    wr(3'd2, 16'h5A00, 1);
    wr(3'd0, 16'h0087, 0);
    idle(4096 * 3);
    rdCheck("R2 div4096", 3'd2, 16'h0003);

    // R10 load on a tick
    wr(3'd0, 16'h0080, 0);
    idle(5);
    busAddr = 3'd2;
    wr(3'd2, 16'h5A40, 1);
    check("R10 load beats tick", echo, 16'h0040);

    // R9 standby
    idle(7);
    standby = 1;
    idle(5);
    rdCheck("R9 standby zero", 3'd2, 16'h0000);
    standby = 0;
    idle(10);
    rdCheck("R9 resumes", 3'd2, 16'h000A);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule